// File: doc/BRIEF.md
# Interlaced Stereo Video Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a parallel pixel interface, one pixel per clock. It covers four scan modes: progressive, interlaced, frame-sequential stereo, and interlaced stereo. It also exports the current field parity, the current eye, and the coordinates of the active pixel. Horizontal timing is shared by every field. Vertical timing comes from four independent parameter sets, one for each pairing of eye and field parity. A set can delay its vertical sync edges by half a line.

Software sets all configuration inputs while holding `soft_rst` high. The block then rests in its hold state with every strobe inactive. When `soft_rst` is released, timing begins at the start of sync of the first field. Each strobe has its own polarity inversion. The output clock edge select is captured while the block is held and stays fixed while timing runs. In interlaced modes the programmed active height is the height of one field, which is half the frame.

The field sequencer is a state machine with five states. HOLD is the configuration state. LODD, LEVEN, RODD and REVEN are the four fields, and each one uses vertical set 0, 1, 2 or 3 respectively. The transitions are:
- release: HOLD to LODD.
- field wrap from LODD: to LEVEN when interlace is enabled, otherwise to RODD when stereo is enabled, otherwise back to LODD.
- field wrap from LEVEN: to RODD when stereo is enabled, otherwise to LODD.
- field wrap from RODD: to REVEN when interlace is enabled, otherwise to LODD.
- field wrap from REVEN: to LODD.
- soft reset: from any state to HOLD.

Top module: `stereo_vtg`

## Requirements
- R1: While `rst_n` is low, and while the block is in HOLD, the raw strobes are inactive: each of `hsync_o`, `vsync_o` and `de_o` equals its inversion bit. The coordinates read 0, and `field_even_o` and `eye_right_o` read 0.
- R2: The line counter h runs from 0 to H-1, where H = sync + back + active + front. The raw horizontal sync is active while h < sync.
- R3: The line counter v of a field counts lines from 0 to V-1, where V is the sum of the selected set's sync, back porch and front porch plus the shared active height. Without a shift, the raw vertical sync is active while v < the selected set's sync width.
- R4: When the selected set's half-line flag is set, the raw vertical sync rises at v = 0 and falls at v = sync width. Both edges occur at the point h = floor(H/2).
- R5: The raw data-enable is active only when h is in [sync+back, sync+back+active) and v is in [vsync+vback, vsync+vback+vactive).
- R6: While data-enable is active, `px_x_o` = h-(sync+back) and `px_y_o` = v-(vsync+vback). Otherwise both read 0.
- R7: Only the fields used by the mode are visited, and they follow the order in the transition list above. Progressive mode uses set 0 only. Interlaced mode uses sets 0 and 1. Stereo mode uses sets 0 and 2. Interlaced stereo uses all four sets.
- R8: `field_even_o` is 1 in LEVEN and REVEN. `eye_right_o` is 1 in RODD and REVEN. Both change only when v wraps to 0, which is the start of the next field's vertical blanking.
- R9: Each strobe output is its raw value XOR its inversion input. `clk_edge_o` takes `cfg_inv_clk` on every cycle spent in HOLD and is otherwise held.
- R10: One cycle after `soft_rst` is sampled low in HOLD, the block is in LODD with h = 0 and v = 0, so horizontal sync is active at once. Asserting `soft_rst` at any point returns the block to HOLD on the next edge.

Every timing value written to the configuration inputs must be at least 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Holds the generator in HOLD while configuration is written |
| cfg_interlace | input | 1 | Enables interlaced field order |
| cfg_stereo | input | 1 | Enables left/right eye sequencing |
| cfg_h_sync | input | H_W | Horizontal sync width in pixels |
| cfg_h_back | input | H_W | Horizontal back porch |
| cfg_h_active | input | H_W | Active pixels per line |
| cfg_h_front | input | H_W | Horizontal front porch |
| cfg_v_sync | input | 4 x V_W | Vertical sync width in lines, per set |
| cfg_v_back | input | 4 x V_W | Vertical back porch, per set |
| cfg_v_front | input | 4 x V_W | Vertical front porch, per set |
| cfg_v_active | input | V_W | Active lines per field |
| cfg_v_halfline | input | 4 | Half-line vertical sync delay, per set |
| cfg_inv_hs | input | 1 | Inverts horizontal sync |
| cfg_inv_vs | input | 1 | Inverts vertical sync |
| cfg_inv_de | input | 1 | Inverts data-enable |
| cfg_inv_clk | input | 1 | Requested output clock edge (1 = falling) |
| hsync_o | output | 1 | Horizontal sync |
| vsync_o | output | 1 | Vertical sync |
| de_o | output | 1 | Data-enable |
| clk_edge_o | output | 1 | Clock edge select captured in HOLD |
| field_even_o | output | 1 | Current field is even |
| eye_right_o | output | 1 | Current field belongs to the right eye |
| px_x_o | output | H_W | Active pixel column |
| px_y_o | output | V_W | Active line within the field |

## Verification
The hardest case to reach is the REVEN field with a half-line shift. The block gets there only after three complete fields in interlaced stereo mode. To exercise the rounding of the half point, the line total must also be odd. The stimulus reaches this case with directed configurations that use an odd line total and set the shift flag on every set, and it runs each configuration across two complete field sequences. Random configurations add every mode and polarity mix. A soft reset issued in the middle of a field confirms that timing restarts from LODD.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

    localparam int NUM_SETS = 4;

    typedef enum logic [2:0] {
        ST_HOLD  = 3'd0,
        ST_LODD  = 3'd1,
        ST_LEVEN = 3'd2,
        ST_RODD  = 3'd3,
        ST_REVEN = 3'd4
    } vtg_state_e;

endpackage

// File: rtl/vtg_hcount.sv
module vtg_hcount #(
    parameter int H_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [H_W-1:0]   cfg_h_sync,
    input  logic [H_W-1:0]   cfg_h_back,
    input  logic [H_W-1:0]   cfg_h_active,
    input  logic [H_W-1:0]   cfg_h_front,
    output logic [H_W-1:0]   hcnt,
    output logic [H_W+1:0]   htotal,
    output logic             line_end,
    output logic             hs_raw,
    output logic             h_in_act,
    output logic [H_W-1:0]   h_rel
);
    localparam int HT_W = H_W + 2;

    logic [HT_W-1:0] hstart;
    logic [HT_W-1:0] hend;
    logic [HT_W-1:0] hx;

    always_comb begin
        htotal   = HT_W'(cfg_h_sync) + HT_W'(cfg_h_back)
                 + HT_W'(cfg_h_active) + HT_W'(cfg_h_front);
        hstart   = HT_W'(cfg_h_sync) + HT_W'(cfg_h_back);
        hend     = hstart + HT_W'(cfg_h_active);
        hx       = HT_W'(hcnt);
        line_end = !clear && (hx == htotal - HT_W'(1));
        hs_raw   = hcnt < cfg_h_sync;
        h_in_act = (hx >= hstart) && (hx < hend);
        h_rel    = H_W'(hx - hstart);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hcnt <= '0;
        else if (clear)    hcnt <= '0;
        else if (line_end) hcnt <= '0;
        else               hcnt <= hcnt + H_W'(1);
    end

    // R2: the counter never passes the programmed line total while running
    p_hcnt_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (HT_W'(hcnt) < htotal));

    // R2: a line end is followed by the start of sync
    p_line_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hcnt == '0));

endmodule

// File: rtl/vtg_vcount.sv
module vtg_vcount
    import vtg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     line_end,
    input  logic [1:0]               set_idx,
    input  logic [H_W-1:0]           hcnt,
    input  logic [H_W+1:0]           htotal,
    input  logic [NUM_SETS-1:0][V_W-1:0] cfg_v_sync,
    input  logic [NUM_SETS-1:0][V_W-1:0] cfg_v_back,
    input  logic [NUM_SETS-1:0][V_W-1:0] cfg_v_front,
    input  logic [V_W-1:0]           cfg_v_active,
    input  logic [NUM_SETS-1:0]      cfg_v_halfline,
    output logic [V_W-1:0]           vcnt,
    output logic                     frame_end,
    output logic                     vs_raw,
    output logic                     v_in_act,
    output logic [V_W-1:0]           v_rel
);
    localparam int VT_W = V_W + 2;
    localparam int HT_W = H_W + 2;

    logic [VT_W-1:0] set_total [NUM_SETS];
    logic [VT_W-1:0] set_start [NUM_SETS];

    for (genvar g = 0; g < NUM_SETS; g++) begin : g_set
        assign set_start[g] = VT_W'(cfg_v_sync[g]) + VT_W'(cfg_v_back[g]);
        assign set_total[g] = set_start[g] + VT_W'(cfg_v_active)
                            + VT_W'(cfg_v_front[g]);
    end

    logic [VT_W-1:0] vtot_sel;
    logic [VT_W-1:0] vstart_sel;
    logic [V_W-1:0]  vsw_sel;
    logic            shift_sel;
    logic [HT_W-1:0] half_pt;
    logic            late_half;
    logic [VT_W-1:0] vx;

    always_comb begin
        vtot_sel   = set_total[set_idx];
        vstart_sel = set_start[set_idx];
        vsw_sel    = cfg_v_sync[set_idx];
        shift_sel  = cfg_v_halfline[set_idx];
        half_pt    = htotal >> 1;
        late_half  = HT_W'(hcnt) >= half_pt;
        vx         = VT_W'(vcnt);
        frame_end  = line_end && (vx == vtot_sel - VT_W'(1));
        if (shift_sel)
            vs_raw = ((vcnt < vsw_sel) && late_half)
                  || ((vcnt != '0) && (vcnt <= vsw_sel) && !late_half);
        else
            vs_raw = vcnt < vsw_sel;
        v_in_act = (vx >= vstart_sel) && (vx < vstart_sel + VT_W'(cfg_v_active));
        v_rel    = V_W'(vx - vstart_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         vcnt <= '0;
        else if (clear)     vcnt <= '0;
        else if (frame_end) vcnt <= '0;
        else if (line_end)  vcnt <= vcnt + V_W'(1);
    end

    // R4: a shifted vertical sync rises at the half-line point, an unshifted one at line start
    p_vs_rise_point_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && $rose(vs_raw)) |->
            (shift_sel ? (HT_W'(hcnt) == half_pt) : (hcnt == '0)));

    // R3: the line counter stays inside the selected field length
    p_vcnt_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |-> (VT_W'(vcnt) < vtot_sel));

endmodule

// File: rtl/vtg_field_fsm.sv
module vtg_field_fsm
    import vtg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       soft_rst,
    input  logic       frame_end,
    input  logic       cfg_interlace,
    input  logic       cfg_stereo,
    output vtg_state_e state,
    output logic       running,
    output logic [1:0] set_idx,
    output logic       field_even,
    output logic       eye_right
);
    vtg_state_e state_nx;

    always_comb begin
        state_nx = state;
        if (soft_rst) begin
            state_nx = ST_HOLD;
        end else begin
            unique case (state)
                ST_HOLD:  state_nx = ST_LODD;
                ST_LODD:  if (frame_end)
                              state_nx = cfg_interlace ? ST_LEVEN
                                       : (cfg_stereo ? ST_RODD : ST_LODD);
                ST_LEVEN: if (frame_end)
                              state_nx = cfg_stereo ? ST_RODD : ST_LODD;
                ST_RODD:  if (frame_end)
                              state_nx = cfg_interlace ? ST_REVEN : ST_LODD;
                ST_REVEN: if (frame_end)
                              state_nx = ST_LODD;
                default:  state_nx = ST_HOLD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_HOLD;
        else        state <= state_nx;
    end

    always_comb begin
        running    = 1'b1;
        set_idx    = 2'd0;
        field_even = 1'b0;
        eye_right  = 1'b0;
        unique case (state)
            ST_HOLD:  running = 1'b0;
            ST_LODD:  set_idx = 2'd0;
            ST_LEVEN: begin set_idx = 2'd1; field_even = 1'b1; end
            ST_RODD:  begin set_idx = 2'd2; eye_right  = 1'b1; end
            ST_REVEN: begin set_idx = 2'd3; field_even = 1'b1; eye_right = 1'b1; end
            default:  running = 1'b0;
        endcase
    end

    // R8: the field changes only at a field wrap, a soft reset, or the release from HOLD
    p_field_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |->
            ($past(frame_end) || $past(soft_rst) || ($past(state) == ST_HOLD)));

    // R7: the right-even field is reached only from the right-odd field
    p_reven_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REVEN) |->
            (($past(state) == ST_REVEN) || ($past(state) == ST_RODD)));

endmodule

// File: rtl/stereo_vtg.sv
module stereo_vtg
    import vtg_pkg::*;
#(
    parameter int H_W = 12,
    parameter int V_W = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         soft_rst,
    input  logic                         cfg_interlace,
    input  logic                         cfg_stereo,
    input  logic [H_W-1:0]               cfg_h_sync,
    input  logic [H_W-1:0]               cfg_h_back,
    input  logic [H_W-1:0]               cfg_h_active,
    input  logic [H_W-1:0]               cfg_h_front,
    input  logic [NUM_SETS-1:0][V_W-1:0] cfg_v_sync,
    input  logic [NUM_SETS-1:0][V_W-1:0] cfg_v_back,
    input  logic [NUM_SETS-1:0][V_W-1:0] cfg_v_front,
    input  logic [V_W-1:0]               cfg_v_active,
    input  logic [NUM_SETS-1:0]          cfg_v_halfline,
    input  logic                         cfg_inv_hs,
    input  logic                         cfg_inv_vs,
    input  logic                         cfg_inv_de,
    input  logic                         cfg_inv_clk,
    output logic                         hsync_o,
    output logic                         vsync_o,
    output logic                         de_o,
    output logic                         clk_edge_o,
    output logic                         field_even_o,
    output logic                         eye_right_o,
    output logic [H_W-1:0]               px_x_o,
    output logic [V_W-1:0]               px_y_o
);
    vtg_state_e      state;
    logic            running;
    logic            clear;
    logic [1:0]      set_idx;
    logic            field_even;
    logic            eye_right;
    logic [H_W-1:0]  hcnt;
    logic [H_W+1:0]  htotal;
    logic            line_end;
    logic            hs_raw;
    logic            h_in_act;
    logic [H_W-1:0]  h_rel;
    logic [V_W-1:0]  vcnt;
    logic            frame_end;
    logic            vs_raw;
    logic            v_in_act;
    logic [V_W-1:0]  v_rel;
    logic            hs_g;
    logic            vs_g;
    logic            de_g;

    assign clear = soft_rst | ~running;

    vtg_field_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .soft_rst      (soft_rst),
        .frame_end     (frame_end),
        .cfg_interlace (cfg_interlace),
        .cfg_stereo    (cfg_stereo),
        .state         (state),
        .running       (running),
        .set_idx       (set_idx),
        .field_even    (field_even),
        .eye_right     (eye_right)
    );

    vtg_hcount #(.H_W(H_W)) u_hcount (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear        (clear),
        .cfg_h_sync   (cfg_h_sync),
        .cfg_h_back   (cfg_h_back),
        .cfg_h_active (cfg_h_active),
        .cfg_h_front  (cfg_h_front),
        .hcnt         (hcnt),
        .htotal       (htotal),
        .line_end     (line_end),
        .hs_raw       (hs_raw),
        .h_in_act     (h_in_act),
        .h_rel        (h_rel)
    );

    vtg_vcount #(.H_W(H_W), .V_W(V_W)) u_vcount (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear          (clear),
        .line_end       (line_end),
        .set_idx        (set_idx),
        .hcnt           (hcnt),
        .htotal         (htotal),
        .cfg_v_sync     (cfg_v_sync),
        .cfg_v_back     (cfg_v_back),
        .cfg_v_front    (cfg_v_front),
        .cfg_v_active   (cfg_v_active),
        .cfg_v_halfline (cfg_v_halfline),
        .vcnt           (vcnt),
        .frame_end      (frame_end),
        .vs_raw         (vs_raw),
        .v_in_act       (v_in_act),
        .v_rel          (v_rel)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                clk_edge_o <= 1'b0;
        else if (state == ST_HOLD) clk_edge_o <= cfg_inv_clk;
    end

    always_comb begin
        hs_g         = running & hs_raw;
        vs_g         = running & vs_raw;
        de_g         = running & h_in_act & v_in_act;
        hsync_o      = hs_g ^ cfg_inv_hs;
        vsync_o      = vs_g ^ cfg_inv_vs;
        de_o         = de_g ^ cfg_inv_de;
        field_even_o = field_even;
        eye_right_o  = eye_right;
        px_x_o       = de_g ? h_rel : '0;
        px_y_o       = de_g ? v_rel : '0;
    end

    // R5: active pixels never overlap horizontal sync
    p_de_outside_sync_r5: assert property (@(posedge clk) disable iff (!rst_n)
        de_g |-> !hs_g);

    // R6: consecutive active pixels advance the column by one
    p_x_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (de_g && $past(de_g)) |-> (px_x_o == $past(px_x_o) + H_W'(1)));

    // R9: the clock edge select does not move while timing runs
    p_clk_edge_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running)) |-> $stable(clk_edge_o));

    // R10: leaving HOLD starts at sync of the first field
    p_release_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HOLD && state != ST_HOLD) |->
            (state == ST_LODD && hcnt == '0 && vcnt == '0));

endmodule

// File: tb/stereo_vtg_bench.sv
module stereo_vtg_bench;
    localparam int HW = 12;
    localparam int VW = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b1;
    logic cfg_interlace = 1'b0, cfg_stereo = 1'b0;
    logic [HW-1:0] cfg_h_sync = 1, cfg_h_back = 1, cfg_h_active = 1, cfg_h_front = 1;
    logic [3:0][VW-1:0] cfg_v_sync, cfg_v_back, cfg_v_front;
    logic [VW-1:0] cfg_v_active = 1;
    logic [3:0] cfg_v_halfline = '0;
    logic cfg_inv_hs = 0, cfg_inv_vs = 0, cfg_inv_de = 0, cfg_inv_clk = 0;
    logic hsync_o, vsync_o, de_o, clk_edge_o, field_even_o, eye_right_o;
    logic [HW-1:0] px_x_o;
    logic [VW-1:0] px_y_o;

    always #4 clk = ~clk;

    stereo_vtg #(.H_W(HW), .V_W(VW)) u_stereo_vtg (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cfg_interlace(cfg_interlace), .cfg_stereo(cfg_stereo),
        .cfg_h_sync(cfg_h_sync), .cfg_h_back(cfg_h_back),
        .cfg_h_active(cfg_h_active), .cfg_h_front(cfg_h_front),
        .cfg_v_sync(cfg_v_sync), .cfg_v_back(cfg_v_back),
        .cfg_v_front(cfg_v_front), .cfg_v_active(cfg_v_active),
        .cfg_v_halfline(cfg_v_halfline),
        .cfg_inv_hs(cfg_inv_hs), .cfg_inv_vs(cfg_inv_vs),
        .cfg_inv_de(cfg_inv_de), .cfg_inv_clk(cfg_inv_clk),
        .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o),
        .clk_edge_o(clk_edge_o), .field_even_o(field_even_o),
        .eye_right_o(eye_right_o), .px_x_o(px_x_o), .px_y_o(px_y_o)
    );

    int nchk = 0;
    int nfail = 0;
    int m_st = 0, m_h = 0, m_v = 0;
    bit m_ce = 0;
    bit first_field = 0;

    task automatic chk(string tag, int got, int exp);
        nchk++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d (state %0d h %0d v %0d)",
                     tag, got, exp, m_st, m_h, m_v);
        end
    endtask

    function automatic int htot();
        return int'(cfg_h_sync) + int'(cfg_h_back) + int'(cfg_h_active) + int'(cfg_h_front);
    endfunction

    function automatic int vtot(int s);
        return int'(cfg_v_sync[s]) + int'(cfg_v_back[s]) + int'(cfg_v_active) + int'(cfg_v_front[s]);
    endfunction

    function automatic int next_field(int st);
        case (st)
            1: return cfg_interlace ? 2 : (cfg_stereo ? 3 : 1);
            2: return cfg_stereo ? 3 : 1;
            3: return cfg_interlace ? 4 : 1;
            default: return 1;
        endcase
    endfunction

    task automatic step();
        if (!rst_n) begin
            m_st = 0; m_h = 0; m_v = 0; m_ce = 0;
            return;
        end
        if (m_st == 0) m_ce = cfg_inv_clk;
        if (soft_rst) begin
            m_st = 0; m_h = 0; m_v = 0;
        end else if (m_st == 0) begin
            m_st = 1; m_h = 0; m_v = 0; first_field = 1;
        end else if (m_h == htot() - 1) begin
            m_h = 0;
            if (m_v == vtot(m_st - 1) - 1) begin
                m_v = 0; m_st = next_field(m_st); first_field = 0;
            end else m_v++;
        end else m_h++;
    endtask

    task automatic check_now();
        bit run, hs, ha, vs, va, de, sh;
        int s, half, vsw, vst, hst;
        run = (m_st != 0);
        s = run ? m_st - 1 : 0;
        half = htot() / 2;
        hst = int'(cfg_h_sync) + int'(cfg_h_back);
        vsw = int'(cfg_v_sync[s]);
        vst = vsw + int'(cfg_v_back[s]);
        sh = cfg_v_halfline[s];
        hs = run && (m_h < int'(cfg_h_sync));
        ha = (m_h >= hst) && (m_h < hst + int'(cfg_h_active));
        if (sh) vs = run && (((m_v < vsw) && (m_h >= half)) ||
                             ((m_v > 0) && (m_v <= vsw) && (m_h < half)));
        else    vs = run && (m_v < vsw);
        va = (m_v >= vst) && (m_v < vst + int'(cfg_v_active));
        de = run && ha && va;
        if (!run || !rst_n) begin
            chk("R1 hsync", hsync_o, cfg_inv_hs);
            chk("R1 vsync", vsync_o, cfg_inv_vs);
            chk("R1 de", de_o, cfg_inv_de);
            chk("R1 x", px_x_o, 0);
            chk("R1 y", px_y_o, 0);
            chk("R1 field", field_even_o, 0);
            chk("R1 eye", eye_right_o, 0);
        end else begin
            chk(first_field && m_v == 0 ? "R10 hsync" : (cfg_inv_hs ? "R9 hsync" : "R2 hsync"),
                hsync_o, hs ^ cfg_inv_hs);
            chk(sh ? "R4 vsync" : (cfg_inv_vs ? "R9 vsync" : "R3 vsync"), vsync_o, vs ^ cfg_inv_vs);
            chk("R5 de", de_o, de ^ cfg_inv_de);
            chk("R6 x", px_x_o, de ? m_h - hst : 0);
            chk("R6 y", px_y_o, de ? m_v - vst : 0);
            chk("R7 field", field_even_o, (m_st == 2 || m_st == 4));
            chk("R8 eye", eye_right_o, (m_st >= 3));
        end
        chk("R9 clk_edge", clk_edge_o, m_ce);
    endtask

    task automatic run_cycles(int n);
        for (int i = 0; i < n; i++) begin
            step();
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic set_cfg(int hs, int hb, int ha, int hf, int va, bit il, bit st3, bit shall);
        cfg_h_sync = HW'(hs); cfg_h_back = HW'(hb);
        cfg_h_active = HW'(ha); cfg_h_front = HW'(hf);
        cfg_v_active = VW'(va); cfg_interlace = il; cfg_stereo = st3;
        for (int i = 0; i < 4; i++) begin
            cfg_v_sync[i]  = VW'(1 + $urandom % 3);
            cfg_v_back[i]  = VW'(1 + $urandom % 3);
            cfg_v_front[i] = VW'(1 + $urandom % 3);
            cfg_v_halfline[i] = shall ? 1'b1 : 1'($urandom % 2);
        end
    endtask

    task automatic configure_and_run(int hs, int hb, int ha, int hf, int va, bit il, bit st3, bit shall);
        soft_rst = 1'b1;
        run_cycles(2);
        set_cfg(hs, hb, ha, hf, va, il, st3, shall);
        cfg_inv_hs = 1'($urandom % 2); cfg_inv_vs = 1'($urandom % 2);
        cfg_inv_de = 1'($urandom % 2); cfg_inv_clk = 1'($urandom % 2);
        run_cycles(3);
        soft_rst = 1'b0;
        run_cycles(2 * 4 * htot() * 15 + 10);
    endtask

    initial begin
        #(8 * 200000);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h1357);
        for (int i = 0; i < 4; i++) begin
            cfg_v_sync[i] = 1; cfg_v_back[i] = 1; cfg_v_front[i] = 1;
        end
        // R1: reset state
        run_cycles(4);
        @(negedge clk);
        rst_n = 1'b1;
        check_now();
        run_cycles(3);
        // R4: odd line total, every set shifted, interlaced stereo
        configure_and_run(1, 1, 2, 1, 2, 1'b1, 1'b1, 1'b1);
        // R2: minimum values, progressive
        configure_and_run(1, 1, 1, 1, 1, 1'b0, 1'b0, 1'b0);
        // R7: interlaced only, then stereo only
        configure_and_run(2, 2, 4, 1, 3, 1'b1, 1'b0, 1'b0);
        configure_and_run(3, 1, 3, 2, 2, 1'b0, 1'b1, 1'b0);
        // R10: soft reset in the middle of a field, then restart
        soft_rst = 1'b0;
        run_cycles(37);
        soft_rst = 1'b1;
        run_cycles(3);
        soft_rst = 1'b0;
        run_cycles(200);
        // random configurations
        for (int k = 0; k < 14; k++) begin
            configure_and_run(1 + $urandom % 3, 1 + $urandom % 3, 2 + $urandom % 5,
                              1 + $urandom % 3, 2 + $urandom % 4,
                              1'($urandom % 2), 1'($urandom % 2), 1'b0);
        end
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule